// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter with an N-bit result. An outside integrator, comparator and reference do the analog work. The block tells the integrator which source to integrate and when to stay discharged, and it counts clock cycles. It also turns the moment the comparator falls into a binary code.

A start request in idle clears an (N+1)-bit counter and releases the integrator. The integrator then integrates the held input for a fixed window of 2^N clocks. The counter's top bit ends that window: when it sets, the integrator is switched to the reference of opposite polarity. The lower N bits are zero at that moment, so they count the second phase from zero. In the second phase the count advances only while the comparator reports that the integrator is still below ground. When the comparator falls, the frozen lower bits are the result, and a one-cycle done pulse marks it. If the lower bits are all ones while the comparator is still high, the conversion stops and an overrange flag is raised.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, intDischarge is 1, selRef is 0, done is 0, result is 0 and overRange is 0.
- R2: A startReq seen at a clock edge while idle gives intDischarge = 0 and selRef = 0 (held input selected) after that edge, and clears overRange.
- R3: The first phase lasts exactly 2^N clocks whatever cmpBelow does. selRef rises after the 2^N-th edge following the edge that accepted the start.
- R4: In the second phase (selRef = 1) the count advances by one on each edge where cmpBelow = 1, and stops on the first edge where cmpBelow = 0.
- R5: On that stopping edge the result register is loaded with the lower N bits of the count. done is 1 for exactly the one cycle after that edge. The block then returns to idle with intDischarge = 1 and selRef = 0.
- R6: If cmpBelow stays 1 for k second-phase edges (k < 2^N), result = k and done is seen 2^N + k + 1 edges after the start edge.
- R7: startReq is ignored while a conversion runs. The selRef and done timing and the result are the same as without it.
- R8: If the lower N bits are all ones and cmpBelow is still 1 on a second-phase edge, the conversion stops at that edge (2^(N+1) edges after the start edge). overRange becomes 1, done stays 0, result is unchanged, and overRange holds until the next start.
- R9: Between conversions, result holds its last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start a conversion; ignored unless idle |
| cmpBelow | input | 1 | Comparator: 1 while integrator output is below ground |
| selRef | output | 1 | Integrator source: 0 held input, 1 opposite-polarity reference |
| intDischarge | output | 1 | 1 holds the integrator discharged |
| result | output | N | Last converted code |
| done | output | 1 | One-cycle pulse when a new result is valid |
| overRange | output | 1 | Set when the second phase runs out of count |

## Verification
All timing is counted in edges from the edge that accepts the start. selRef is due after edge 2^N. done and the new result are due after edge 2^N + k + 1. An overrange is due after edge 2^(N+1). The bench models the integrator as a signed accumulator. It reads the outputs at every falling edge, counts edges from the start edge, and compares the edge at which each event first appears against these counts, so an event one cycle early or late is reported.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef struct packed {
    logic clear;    // zero the counter, drop overrange
    logic countEn;  // advance the counter by one
    logic capture;  // load result from low count bits
    logic setOver;  // raise overrange
  } dpStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seqState_t;
endpackage

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import dsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      cmpBelow,
  input  logic      cntMsb,
  input  logic      lowAllOnes,
  output dpStrobe_t strb,
  output logic      selRef,
  output logic      intDischarge,
  output logic      done
);
  seqState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.clear = 1'b1;
          stateNext  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!cntMsb) begin
          // fixed-length first phase
          strb.countEn = 1'b1;
        end else if (cmpBelow) begin
          if (lowAllOnes) begin
            strb.setOver = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            strb.countEn = 1'b1;
          end
        end else begin
          strb.capture = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.capture;
    end
  end

  assign selRef       = (state == ST_RUN) && cntMsb;
  assign intDischarge = (state == ST_IDLE);
endmodule

// File: rtl/dual_slope_dp.sv
module dual_slope_dp
  import dsc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  output logic          cntMsb,
  output logic          lowAllOnes,
  output logic [N-1:0]  result,
  output logic          overRange
);
  localparam int CW = N + 1;

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      result    <= '0;
      overRange <= 1'b0;
    end else begin
      if (strb.clear)        count <= '0;
      else if (strb.countEn) count <= count + 1'b1;

      if (strb.capture) result <= count[N-1:0];

      if (strb.clear)        overRange <= 1'b0;
      else if (strb.setOver) overRange <= 1'b1;
    end
  end

  assign cntMsb     = count[CW-1];
  assign lowAllOnes = &count[N-1:0];
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         cmpBelow,
  output logic         selRef,
  output logic         intDischarge,
  output logic [N-1:0] result,
  output logic         done,
  output logic         overRange
);
  dpStrobe_t strb;
  logic      cntMsb;
  logic      lowAllOnes;

  dual_slope_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpBelow(cmpBelow),
    .cntMsb(cntMsb), .lowAllOnes(lowAllOnes), .strb(strb),
    .selRef(selRef), .intDischarge(intDischarge), .done(done)
  );

  dual_slope_dp #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntMsb(cntMsb),
    .lowAllOnes(lowAllOnes), .result(result), .overRange(overRange)
  );
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         cmpBelow,
  input logic         selRef,
  input logic         intDischarge,
  input logic [N-1:0] result,
  input logic         done,
  input logic         overRange
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_after_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(selRef && !cmpBelow));

  // R2
  src_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(intDischarge && selRef));

  // R8
  ref_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selRef) |-> (done || $rose(overRange)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  // R8
  over_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overRange) |-> $past(selRef && cmpBelow));
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .cmpBelow(cmpBelow), .selRef(selRef),
  .intDischarge(intDischarge), .result(result), .done(done),
  .overRange(overRange)
);

// File: tb/dual_slope_seq_bench.sv
`timescale 1ns/1ps
module dual_slope_seq_bench;
  localparam int N    = 8;
  localparam int FULL = 1 << N;
  localparam int NVEC = 6;
  localparam int VEC [NVEC] = '{0, 1, 37, 128, 200, 255};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         cmpBelow;
  logic         selRef, intDischarge, done, overRange;
  logic [N-1:0] result;

  int checks = 0;
  int fails  = 0;
  int vinReg = 0;
  int integ  = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_slope_seq #(.N(N)) u_dual_slope_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpBelow(cmpBelow),
    .selRef(selRef), .intDischarge(intDischarge), .result(result),
    .done(done), .overRange(overRange)
  );

  // integrator model: input pushes negative, reference step 2^N back up
  always @(posedge clk) begin
    if (intDischarge)  integ <= 0;
    else if (!selRef)  integ <= integ - vinReg;
    else               integ <= integ + FULL;
  end
  assign cmpBelow = (integ < 0);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic convert(input int vin, input bit poke,
                         output int selAt, output int doneAt, output int overAt);
    selAt = -1; doneAt = -1; overAt = -1;
    vinReg = vin;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    chk(!intDischarge && !selRef, "R2", "released/input", {30'd0, intDischarge, selRef}, 0);
    chk(overRange == 1'b0, "R2", "overRange cleared", int'(overRange), 0);
    for (int n = 1; n <= 3 * FULL; n++) begin
      startReq = poke && (n == 100 || n == FULL + 20);
      @(negedge clk);
      if (selRef && selAt < 0) selAt = n;
      if (done)      begin doneAt = n; break; end
      if (overRange) begin overAt = n; break; end
    end
    startReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int selAt, doneAt, overAt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(intDischarge == 1'b1, "R1", "intDischarge", int'(intDischarge), 1);
    chk(selRef == 1'b0,       "R1", "selRef",       int'(selRef), 0);
    chk(done == 1'b0,         "R1", "done",         int'(done), 0);
    chk(result == '0,         "R1", "result",       int'(result), 0);
    chk(overRange == 1'b0,    "R1", "overRange",    int'(overRange), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      convert(VEC[i], 1'b0, selAt, doneAt, overAt);
      chk(selAt == FULL, "R3", "selRef rise edge", selAt, FULL);
      chk(int'(result) == VEC[i], "R6", "result code", int'(result), VEC[i]);
      chk(doneAt == FULL + VEC[i] + 1, "R4", "done edge", doneAt, FULL + VEC[i] + 1);
      chk(!done && intDischarge && !selRef, "R5", "single pulse then idle",
          {29'd0, done, intDischarge, selRef}, 2);
    end

    // R7: starts in both phases must not disturb the conversion
    convert(77, 1'b1, selAt, doneAt, overAt);
    chk(selAt == FULL, "R7", "selRef edge with stray start", selAt, FULL);
    chk(doneAt == FULL + 78, "R7", "done edge with stray start", doneAt, FULL + 78);
    chk(int'(result) == 77, "R7", "result with stray start", int'(result), 77);

    // R8: input of 2^N runs out of count
    convert(FULL, 1'b0, selAt, doneAt, overAt);
    chk(overAt == 2 * FULL, "R8", "overrange edge", overAt, 2 * FULL);
    chk(doneAt == -1, "R8", "no done on overrange", doneAt, -1);
    chk(int'(result) == 77, "R8", "result kept", int'(result), 77);
    chk(intDischarge == 1'b1, "R8", "back to idle", int'(intDischarge), 1);

    // R9: hold across idle cycles
    repeat (10) @(negedge clk);
    chk(int'(result) == 77, "R9", "result held", int'(result), 77);
    chk(overRange == 1'b1, "R8", "overRange held", int'(overRange), 1);

    // R2 clears overrange on the next start, then normal result
    convert(5, 1'b0, selAt, doneAt, overAt);
    chk(int'(result) == 5, "R6", "result after overrange", int'(result), 5);
    chk(overAt == -1 && overRange == 1'b0, "R2", "overRange low",
        int'(overRange), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule